// File: doc/BRIEF.md
# Converter Leg Dead-Time Controller

This block turns a single pulse-width command for one half-bridge leg into two gate drives, one for the upper switch and one for the lower switch. Each time the command asks the leg to change side, the block first turns the conducting switch off. It then holds both gates low for a programmable number of clock cycles before it turns the other switch on. The two switches are therefore never driven at the same time.

The command first passes through a two-stage synchronizer. A width filter follows. It drops any high pulse or low notch that is shorter than a programmable number of cycles, and it raises a one-cycle flag for each pulse it drops. A five-state machine then drives the gates. Its states are off, upper on, lower on, and one blanking state for each direction of travel.

All pins are plain control and status signals; there is no data stream and no back-pressure. The blanking length and the minimum width are taken from their inputs only while the machine is not blanking.

Top module: `dtc_leg_ctrl`

## Requirements
- R1: While reset is held, both gates and the fault flag are low. One clock edge after `enable` is sampled low, both gates are low. While `enable` stays low, activity on `pwm_cmd` never raises either gate.
- R2: `gate_top` and `gate_bot` are never high in the same cycle.
- R3: With the leg steady and minimum width M (M ≥ 1), a change of `pwm_cmd` drops the conducting gate exactly 3+M clock edges later. This delay is two synchronizer stages, M filter cycles and one state-machine edge. The opposite gate rises exactly D edges after that, where D is the blanking count.
- R4: When `enable` rises from the off state, both gates stay low for D cycles. Then the gate matching the filtered command (high selects `gate_top`, low selects `gate_bot`) rises D+1 edges after `enable` is first sampled high.
- R5: A high pulse or low notch on `pwm_cmd` lasting fewer than M cycles leaves both gate outputs unchanged.
- R6: Each rejected pulse of width W raises `narrow_fault` for exactly one cycle, W+3 edges after the pulse starts.
- R7: A pulse lasting exactly M cycles is accepted and moves the leg. A minimum width of 0 behaves as 1.
- R8: `dead_cycles` and `min_width` are captured only while the machine is off or steady on one side. A change made during blanking does not alter the blanking in progress.
- R9: If the filtered command reverses during blanking, the blanking still runs its full D cycles. At its end, the gate matching the current command turns on, which may be the gate that was just switched off.
- R10: A blanking count of 0 behaves as 1, so at least one cycle with both gates low separates every hand-over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Leg enable; low forces both gates off |
| pwm_cmd | input | 1 | Asynchronous command, high requests the upper switch |
| dead_cycles | input | 8 | Blanking length in clock cycles |
| min_width | input | 8 | Shortest accepted pulse or notch in cycles |
| gate_top | output | 1 | Upper switch gate drive |
| gate_bot | output | 1 | Lower switch gate drive |
| narrow_fault | output | 1 | One-cycle flag for each rejected narrow pulse |

## Verification
A wrong state-machine state shows up at the gate pins in the same cycle. It appears either as a gate high during what should be blanking or as a hand-over edge that arrives one or more cycles early or late. The scoreboard predicts the exact edge of every change on the three outputs from the timing in R3, R4 and R6. Any shift, extra edge or missing edge is therefore caught the cycle it happens. A filter counter that miscounts appears as a fault flag on an accepted pulse, or as a gate hand-over after a pulse that should have been dropped.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_TOP    = 3'd1,
    ST_BOT    = 3'd2,
    ST_BLK_UP = 3'd3,
    ST_BLK_DN = 3'd4
  } leg_state_e;
endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dtc_glitch_filter.sv
module dtc_glitch_filter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic [CW-1:0] min_w,
  output logic          level,
  output logic          reject
);
  logic [CW-1:0] run_q;
  logic [CW:0]   run_nxt;
  logic [CW:0]   thr;
  logic          differ;

  assign differ  = raw ^ level;
  assign run_nxt = {1'b0, run_q} + 1'b1;
  assign thr     = (min_w == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, min_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= 1'b0;
      run_q  <= '0;
      reject <= 1'b0;
    end else begin
      reject <= !differ && (run_q != '0);
      if (differ) begin
        if (run_nxt >= thr) begin
          level <= raw;
          run_q <= '0;
        end else begin
          run_q <= run_nxt[CW-1:0];
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject);

  assert_level_follows_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> ($past(raw) == level));
endmodule

// File: rtl/dtc_leg_fsm.sv
module dtc_leg_fsm
  import dtc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cmd,
  input  logic [CW-1:0] dead,
  output logic          gate_top,
  output logic          gate_bot,
  output logic          steady
);
  leg_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dead_eff;

  assign dead_eff = (dead == '0) ? {{(CW-1){1'b0}}, 1'b1} : dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else if (!en) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_q  <= cmd ? ST_BLK_UP : ST_BLK_DN;
          cnt_q <= {{(CW-1){1'b0}}, 1'b1};
        end
        ST_TOP: if (!cmd) begin
          st_q  <= ST_BLK_DN;
          cnt_q <= {{(CW-1){1'b0}}, 1'b1};
        end
        ST_BOT: if (cmd) begin
          st_q  <= ST_BLK_UP;
          cnt_q <= {{(CW-1){1'b0}}, 1'b1};
        end
        ST_BLK_UP, ST_BLK_DN: begin
          if (cnt_q >= dead_eff) begin
            st_q  <= cmd ? ST_TOP : ST_BOT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_OFF;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign gate_top = (st_q == ST_TOP);
  assign gate_bot = (st_q == ST_BOT);
  assign steady   = (st_q == ST_OFF) || (st_q == ST_TOP) || (st_q == ST_BOT);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_top && gate_bot));

  assert_break_before_make_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_top) || $rose(gate_bot)) |-> !$past(gate_top || gate_bot));

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_top && !gate_bot));
endmodule

// File: rtl/dtc_leg_ctrl.sv
module dtc_leg_ctrl #(
  parameter int CFG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pwm_cmd,
  input  logic [CFG_W-1:0] dead_cycles,
  input  logic [CFG_W-1:0] min_width,
  output logic             gate_top,
  output logic             gate_bot,
  output logic             narrow_fault
);
  logic             cmd_sync;
  logic             cmd_clean;
  logic             fsm_steady;
  logic [CFG_W-1:0] dead_q;
  logic [CFG_W-1:0] minw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_q <= '0;
      minw_q <= '0;
    end else if (fsm_steady) begin
      dead_q <= dead_cycles;
      minw_q <= min_width;
    end
  end

  dtc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pwm_cmd),
    .dout (cmd_sync)
  );

  dtc_glitch_filter #(.CW(CFG_W)) filt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (cmd_sync),
    .min_w (minw_q),
    .level (cmd_clean),
    .reject(narrow_fault)
  );

  dtc_leg_fsm #(.CW(CFG_W)) fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .cmd     (cmd_clean),
    .dead    (dead_q),
    .gate_top(gate_top),
    .gate_bot(gate_bot),
    .steady  (fsm_steady)
  );

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsm_steady && $past(!fsm_steady)) |-> ($stable(dead_q) && $stable(minw_q)));
endmodule

// File: tb/dtc_leg_ctrl_tb.sv
module dtc_leg_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       pwm_cmd = 1'b0;
  logic [7:0] dead_cycles = 8'd5;
  logic [7:0] min_width = 8'd1;
  logic       gate_top, gate_bot, narrow_fault;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int overlap = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [2:0] v;
    string      tag;
  } ev_t;
  ev_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtc_leg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_cmd(pwm_cmd),
    .dead_cycles(dead_cycles), .min_width(min_width),
    .gate_top(gate_top), .gate_bot(gate_bot), .narrow_fault(narrow_fault)
  );

  task automatic expect_at(input int at, input logic [2:0] v, input string tag);
    ev_t e;
    e.at = at; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic direct(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {gate_top, gate_bot, narrow_fault};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops scoreboard entries as output changes appear
  logic [2:0] prev = 3'b000;
  always @(negedge clk) begin
    logic [2:0] cur;
    cur = {gate_top, gate_bot, narrow_fault};
    if (gate_top && gate_bot) overlap++;
    while (q.size() > 0 && q[0].at < cyc) begin
      checks++; fails++;
      $display("FAIL %s: missing change at cycle %0d act=%b exp=%b", q[0].tag, q[0].at, cur, q[0].v);
      void'(q.pop_front());
    end
    if (cur !== prev) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: unexpected change at cycle %0d act=%b exp=%b", cyc, cur, prev);
      end else begin
        ev_t e;
        e = q.pop_front();
        checks++;
        if (e.at != cyc || e.v !== cur) begin
          fails++;
          $display("FAIL %s: change at cycle %0d act=%b exp=%b at cycle %0d", e.tag, cyc, cur, e.v, e.at);
        end
      end
    end
    prev = cur;
  end

  initial begin
    int c;
    ticks(3);
    direct(3'b000, "R1 in reset");
    rst_n = 1'b1;
    ticks(2);
    direct(3'b000, "R1 after reset");
    // R1: toggling while disabled must not move gates
    pwm_cmd = 1'b1; ticks(7); pwm_cmd = 1'b0; ticks(3);
    pwm_cmd = 1'b1; ticks(4); pwm_cmd = 1'b0; ticks(10);
    direct(3'b000, "R1 disabled");

    // R4: enable start-up, D=5
    c = cyc; enable = 1'b1;
    expect_at(c + 6, 3'b010, "R4");
    ticks(15);

    // R3: rise then fall with M=1, D=5
    c = cyc; pwm_cmd = 1'b1;
    expect_at(c + 4, 3'b000, "R3");
    expect_at(c + 9, 3'b100, "R3");
    ticks(15);
    c = cyc; pwm_cmd = 1'b0;
    expect_at(c + 4, 3'b000, "R3");
    expect_at(c + 9, 3'b010, "R3");
    ticks(15);

    // new config taken while steady (R8): D=12, M=4
    dead_cycles = 8'd12; min_width = 8'd4;
    ticks(3);
    // R5/R6: narrow high pulse W=2
    c = cyc; pwm_cmd = 1'b1; ticks(2); pwm_cmd = 1'b0;
    expect_at(c + 5, 3'b011, "R6");
    expect_at(c + 6, 3'b010, "R6");
    ticks(15);

    // wide rise to upper side
    c = cyc; pwm_cmd = 1'b1;
    expect_at(c + 7, 3'b000, "R3");
    expect_at(c + 19, 3'b100, "R3");
    ticks(30);

    // R5/R6: narrow low notch W=3
    c = cyc; pwm_cmd = 1'b0; ticks(3); pwm_cmd = 1'b1;
    expect_at(c + 6, 3'b101, "R6");
    expect_at(c + 7, 3'b100, "R6");
    ticks(15);

    // R7 + R9: notch of exactly M is accepted, command returns during blanking
    c = cyc; pwm_cmd = 1'b0; ticks(4); pwm_cmd = 1'b1;
    expect_at(c + 7, 3'b000, "R7");
    expect_at(c + 19, 3'b100, "R9");
    ticks(30);

    // R8: blanking length change during blanking ignored
    c = cyc; pwm_cmd = 1'b0;
    expect_at(c + 7, 3'b000, "R8");
    expect_at(c + 19, 3'b010, "R8");
    ticks(9); dead_cycles = 8'd3;
    ticks(25);

    // R10: zero blanking behaves as one cycle
    dead_cycles = 8'd0;
    ticks(3);
    c = cyc; pwm_cmd = 1'b1;
    expect_at(c + 7, 3'b000, "R10");
    expect_at(c + 8, 3'b100, "R10");
    ticks(15);

    // R1: disable while on
    c = cyc; enable = 1'b0;
    expect_at(c + 1, 3'b000, "R1");
    ticks(10);
    direct(3'b000, "R1 after disable");

    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R3: %0d expected changes never seen act=0 exp=0", q.size());
    end
    checks++;
    if (overlap != 0) begin
      fails++;
      $display("FAIL R2: overlap cycles act=%0d exp=0", overlap);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1: watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule